// File: doc/BRIEF.md
# Retransmit-capable synchronous FIFO controller

This block stores 9-bit words in an inferred register array and hands them back in arrival order. A write port and a read port each have an active-high enable strobe. Three status outputs report the fill state: empty, full, and more than half full. Every decision is made on one rising clock edge, and the read word and all status outputs are registered.

A rewind strobe moves only the read pointer back to the first location. The words written since reset can then be read again, while the write side keeps its place. At the two boundaries a held opposite strobe completes the waiting operation in the same cycle. If a write arrives while the array is empty and read is held, the word passes straight to the output. If a read happens while the array is full and write is held, the write is accepted into the slot being freed.

`rd_valid` takes the place of an output enable. It is high only while read is held and a word has been delivered. The depth is a parameter and must be a power of two: 256, 512 or 1024.

Top module: `rt_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, both pointers and the stored count are cleared. After that edge `empty`=1, `full`=0, `half_full`=0 and `rd_valid`=0.
- R2: A read taken at edge N puts the oldest stored word on `rd_data`, with `rd_valid`=1, after edge N. Words leave in the order they were written.
- R3: A write while `full`=1 with `rd_en`=0 stores nothing and changes no flag. A read while `empty`=1 with `wr_en`=0 leaves the read pointer unchanged and delivers no new word.
- R4: `full` is 1 exactly when accepted writes exceed accepted reads by DEPTH.
- R5: `half_full` rises on the write that takes the count from DEPTH/2 to DEPTH/2+1. It falls only when a read brings the count back to exactly DEPTH/2.
- R6: `rewind`=1 with both strobes low sets the read pointer to location 0 and leaves the write pointer unchanged. The count becomes the write pointer value, and all flags follow from that count. This is defined only while fewer than DEPTH writes have been accepted since reset.
- R7: `rewind` has no effect in any cycle where `wr_en` or `rd_en` is 1. That cycle behaves as if `rewind` were 0.
- R8: When `empty`=1 and both `wr_en` and `rd_en` are 1, the incoming word appears on `rd_data` with `rd_valid`=1 after that edge. The count stays 0, so `empty` stays 1.
- R9: When `full`=1 and both `wr_en` and `rd_en` are 1, the oldest word is read and the incoming word is stored in the same cycle. `full` stays 1.
- R10: `rd_valid` falls after any edge with `rd_en`=0. When the last word is read, `empty` rises, but `rd_valid` and `rd_data` hold while `rd_en` stays 1.
- R11: A read and a write in the same cycle, with the FIFO neither empty nor full, both complete and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read strobe, also the output enable |
| rewind | input | 1 | Return the read pointer to location 0 |
| rd_data | output | 9 | Word delivered by the last read |
| rd_valid | output | 1 | `rd_data` holds a delivered word |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| half_full | output | 1 | More than DEPTH/2 words stored |

## Verification
Every result is due exactly one edge after the strobes that cause it. This applies to the flags, the read word, `rd_valid` and the rewind result, because the count and the output register are the only state between inputs and outputs. The bench drives a new set of strobes on each falling edge and lets one rising edge pass. It then compares every output on the next falling edge against a bench model that has been advanced by the same step. No result is ever sampled at the edge that produces it.

// File: rtl/rt_fifo_pkg.sv
// Shared word type and per-cycle operation decision for the retransmit FIFO.
package rt_fifo_pkg;
    parameter int WORD_W = 9;

    typedef logic [WORD_W-1:0] word_t;

    // What happens on the coming clock edge.
    typedef struct packed {
        logic wr_take;   // word is stored at the write pointer
        logic rd_take;   // oldest stored word is read out
        logic pass_thru; // empty array: incoming word goes straight to output
        logic rewind;    // read pointer returns to location 0
    } fifo_op_t;
endpackage

// File: rtl/rt_fifo_ctrl.sv
// Decides, from the strobes and the current flags, which operations occur
// on the next edge. Assumes the flags come from the registered count.
module rt_fifo_ctrl
    import rt_fifo_pkg::*;
(
    input  logic     wr_req,
    input  logic     rd_req,
    input  logic     rewind_req,
    input  logic     is_empty,
    input  logic     is_full,
    output fifo_op_t op
);
    // Resolve boundary cases: a held opposite strobe completes a blocked operation.
    always_comb begin
        op.rewind    = rewind_req & ~wr_req & ~rd_req;
        op.wr_take   = wr_req & (~is_full | rd_req);
        op.rd_take   = rd_req & ~is_empty;
        op.pass_thru = rd_req & wr_req & is_empty;
    end
endmodule

// File: rtl/rt_fifo_ptrs.sv
// Holds the write pointer, the read pointer and the stored-word count.
// Assumes DEPTH is a power of two, so pointers wrap naturally.
module rt_fifo_ptrs
    import rt_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fifo_op_t      op,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] level
);
    logic rd_adv;

    // Read side advances on a normal read or a pass-through.
    always_comb rd_adv = op.rd_take | op.pass_thru;

    // Update pointers and count; rewind overrides all other updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (op.rewind) begin
            rd_ptr <= '0;
            level  <= {1'b0, wr_ptr};
        end else begin
            if (op.wr_take) wr_ptr <= wr_ptr + 1'b1;
            if (rd_adv)     rd_ptr <= rd_ptr + 1'b1;
            level <= level + CW'(op.wr_take) - CW'(rd_adv);
        end
    end
endmodule

// File: rtl/rt_fifo_store.sv
// Register array plus the registered output word and its valid bit.
// Assumes a read and a write at the same address return the old word.
module rt_fifo_store
    import rt_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fifo_op_t      op,
    input  logic          rd_req,
    input  logic [AW-1:0] wr_ptr,
    input  logic [AW-1:0] rd_ptr,
    input  word_t         wr_word,
    output word_t         rd_word,
    output logic          rd_ok
);
    word_t mem [DEPTH];

    // Store accepted words; the array itself is not reset.
    always_ff @(posedge clk) begin
        if (op.wr_take) mem[wr_ptr] <= wr_word;
    end

    // Deliver the read word; keep it valid only while read stays held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
            rd_ok   <= 1'b0;
        end else if (op.rd_take) begin
            rd_word <= mem[rd_ptr];
            rd_ok   <= 1'b1;
        end else if (op.pass_thru) begin
            rd_word <= wr_word;
            rd_ok   <= 1'b1;
        end else if (!rd_req) begin
            rd_ok   <= 1'b0;
        end
    end
endmodule

// File: rtl/rt_fifo_flags.sv
// Derives empty, full and above-half flags from the registered count.
// Because the count is exact, the above-half flag sets and clears at the exact thresholds.
module rt_fifo_flags #(
    parameter int DEPTH = 256,
    localparam int CW = $clog2(DEPTH) + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic [CW-1:0] level,
    output logic          is_empty,
    output logic          is_full,
    output logic          is_half
);
    // Compare the count against the three thresholds.
    always_comb begin
        is_empty = (level == '0);
        is_full  = (level == CW'(DEPTH));
        is_half  = (level > CW'(HALF));
    end
endmodule

// File: rtl/rt_fifo.sv
// Top of the single-clock FIFO with read-pointer rewind.
// Assumes a synchronous active-low reset before first use and a power-of-two DEPTH.
module rt_fifo
    import rt_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rewind,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty,
    output logic              full,
    output logic              half_full
);
    fifo_op_t      op;
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    logic [CW-1:0] level_q;

    rt_fifo_ctrl u_ctrl (
        .wr_req    (wr_en),
        .rd_req    (rd_en),
        .rewind_req(rewind),
        .is_empty  (empty),
        .is_full   (full),
        .op        (op)
    );

    rt_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .wr_ptr(wr_ptr_q),
        .rd_ptr(rd_ptr_q),
        .level (level_q)
    );

    rt_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .rd_req (rd_en),
        .wr_ptr (wr_ptr_q),
        .rd_ptr (rd_ptr_q),
        .wr_word(wr_data),
        .rd_word(rd_data),
        .rd_ok  (rd_valid)
    );

    rt_fifo_flags #(.DEPTH(DEPTH)) u_flags (
        .level   (level_q),
        .is_empty(empty),
        .is_full (full),
        .is_half (half_full)
    );
endmodule

// File: rtl/rt_fifo_chk.sv
// Temporal checks on the FIFO ports and its pointer and count state.
// It is attached to every rt_fifo instance through the bind at the end of this file.
module rt_fifo_chk #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1,
    localparam int HALF = DEPTH / 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [8:0]    wr_data,
    input logic          rd_en,
    input logic          rewind,
    input logic [8:0]    rd_data,
    input logic          rd_valid,
    input logic          empty,
    input logic          full,
    input logic          half_full,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] rd_ptr,
    input logic [CW-1:0] level
);
    // R3: a lone write to a full array changes nothing
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && !rd_en |=> full && $stable(wr_ptr));

    // R3: a lone read of an empty array leaves the read pointer in place
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        empty && rd_en && !wr_en |=> empty && $stable(rd_ptr));

    // R5: crossing above half on a write sets the flag
    a_r5_half_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !rewind && wr_en && !rd_en && level == CW'(HALF) |=> half_full);

    // R6: rewind returns the read pointer and keeps the write pointer
    a_r6_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        rewind && !wr_en && !rd_en |=> rd_ptr == '0 && $stable(wr_ptr));

    // R8: pass-through from an empty array
    a_r8_pass_thru: assert property (@(posedge clk) disable iff (!rst_n)
        empty && wr_en && rd_en |=> rd_valid && rd_data == $past(wr_data) && empty);

    // R10: output marked invalid after read is released
    a_r10_idle_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R11: balanced read and write keep the count
    a_r11_balanced: assert property (@(posedge clk) disable iff (!rst_n)
        !empty && !full && wr_en && rd_en |=> $stable(level));
endmodule

bind rt_fifo rt_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rewind   (rewind),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .empty    (empty),
    .full     (full),
    .half_full(half_full),
    .wr_ptr   (wr_ptr_q),
    .rd_ptr   (rd_ptr_q),
    .level    (level_q)
);

// File: tb/sim_rt_fifo.sv
module sim_rt_fifo;
    localparam int D = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       rewind = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       rd_valid, empty, full, half_full;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model of the requirements
    logic [8:0] m_mem [D];
    int         m_wp, m_rp, m_cnt, m_wrs;
    bit         m_vld;
    logic [8:0] m_dat;

    always #4 clk = ~clk;

    rt_fifo #(.DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rewind(rewind), .rd_data(rd_data), .rd_valid(rd_valid),
        .empty(empty), .full(full), .half_full(half_full)
    );

    task automatic cmp(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_wp = 0; m_rp = 0; m_cnt = 0; m_wrs = 0; m_vld = 0; m_dat = '0;
    endtask

    // advance the model by one edge with the given strobes
    task automatic model_step(bit w, logic [8:0] wd, bit r, bit rt);
        bit emp, ful, wacc, racc, byp;
        if (rt && !w && !r) begin
            m_rp = 0; m_cnt = m_wp; m_vld = 0;
            return;
        end
        emp  = (m_cnt == 0);
        ful  = (m_cnt == D);
        wacc = w && (!ful || r);
        racc = r && !emp;
        byp  = r && w && emp;
        if (racc) begin m_dat = m_mem[m_rp]; m_vld = 1; end
        else if (byp) begin m_dat = wd; m_vld = 1; end
        else if (!r) m_vld = 0;
        if (wacc) begin m_mem[m_wp] = wd; m_wp = (m_wp + 1) % D; m_wrs++; end
        if (racc || byp) m_rp = (m_rp + 1) % D;
        m_cnt = m_cnt + int'(wacc) - int'(racc || byp);
    endtask

    task automatic check_outs(string tag);
        cmp(tag, "empty", int'(empty), int'(m_cnt == 0));
        cmp(tag, "full", int'(full), int'(m_cnt == D));
        cmp(tag, "half_full", int'(half_full), int'(m_cnt > D / 2));
        cmp(tag, "rd_valid", int'(rd_valid), int'(m_vld));
        if (m_vld) cmp(tag, "rd_data", int'(rd_data), int'(m_dat));
    endtask

    // drive at the falling edge, let one rising edge pass, check at the next falling edge
    task automatic step(bit w, logic [8:0] wd, bit r, bit rt, string tag);
        wr_en = w; wr_data = wd; rd_en = r; rewind = rt;
        model_step(w, wd, r, rt);
        @(posedge clk);
        @(negedge clk);
        check_outs(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 0; rd_en = 0; rewind = 0;
        model_reset();
        @(posedge clk);
        @(negedge clk);
        check_outs("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd7349);
        @(negedge clk);
        do_reset();

        // R2: order of delivery, R10: last word stays valid while held
        for (int i = 0; i < 3; i++) step(1, 9'(16 + i), 0, 0, "R2");
        for (int i = 0; i < 3; i++) step(0, '0, 1, 0, "R2");
        step(0, '0, 1, 0, "R10");
        step(0, '0, 0, 0, "R10");
        // R3: read while empty
        step(0, '0, 1, 0, "R3");
        step(0, '0, 0, 0, "R3");
        // R8: pass-through
        step(1, 9'h1A5, 1, 0, "R8");
        step(0, '0, 0, 0, "R8");
        // R5: half boundary
        for (int i = 0; i < D / 2 + 1; i++) step(1, 9'(i * 3), 0, 0, "R5");
        step(0, '0, 1, 0, "R5");
        step(1, 9'h0F0, 0, 0, "R5");
        // R4: fill to the top
        while (m_cnt < D) step(1, 9'(m_cnt * 7), 0, 0, "R4");
        // R3: write while full ignored
        step(1, 9'h155, 0, 0, "R3");
        step(0, '0, 0, 0, "R3");
        // R9: held write completes with a read while full
        step(1, 9'h0AA, 1, 0, "R9");
        step(0, '0, 0, 0, "R9");
        // drain everything and check order
        while (m_cnt > 0) step(0, '0, 1, 0, "R2");
        step(0, '0, 0, 0, "R2");

        // R6: rewind
        do_reset();
        for (int i = 0; i < 5; i++) step(1, 9'(100 + i), 0, 0, "R6");
        step(0, '0, 1, 0, "R6");
        step(0, '0, 1, 0, "R6");
        step(0, '0, 0, 1, "R6");
        for (int i = 0; i < 5; i++) step(0, '0, 1, 0, "R6");
        step(0, '0, 0, 0, "R6");
        // R7: rewind ignored while a strobe is active
        step(0, '0, 0, 1, "R6");
        step(0, '0, 1, 1, "R7");
        step(1, 9'h033, 0, 1, "R7");
        step(0, '0, 0, 0, "R7");
        // R11: balanced traffic
        for (int i = 0; i < 6; i++) step(1, 9'(200 + i), 1, 0, "R11");
        step(0, '0, 0, 0, "R11");

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            bit w, r, rt;
            int unsigned pw;
            if (i % 1000 == 0) do_reset();
            pw = ((i / 400) % 2 == 0) ? 75 : 30;
            w  = ($urandom % 100) < pw;
            r  = ($urandom % 100) < (100 - pw);
            rt = ($urandom % 40) == 0;
            if (m_wrs >= D) rt = 0;
            step(w, 9'($urandom), r, rt, "R2");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule